// File: doc/BRIEF.md
# SD/MMC Command Line Sequencer

This block turns a command descriptor into activity on the one-bit command line of an SD/MMC bus. A host register interface presents a descriptor (command index, 32-bit argument, response kind and special-command code) together with a write strobe. If the sequencer is free, it latches the descriptor, drops its ready flag and shifts out a 48-bit frame. The frame carries a 7-bit CRC that the block computes itself. Depending on the response kind, it then releases the line and collects a short or long reply from the card. For one kind it also waits for the card to release data line 0.

Three special codes alter the sequence. An initialisation code puts a 74-clock burst of ones on the line before the frame. A synchronised code holds the frame back until the data engine reports the end of the current block. An interrupt-mode code waits for the card's reply with no timeout. While it waits, the only write that gets through is one carrying the interrupt-response code, which then sends its own frame in place of the wait. Each clock of the block is one command-clock period. Clock division happens outside.

Top module: `sdcmd_seq`

## Requirements
- R1: An accepted command is sent as 48 bits, most significant first, one bit per clock, with `cmd_oe` high. The first bit appears in the cycle after the accepting edge. The bits in order are a 0, a 1, the 6-bit index, the 32-bit argument, a CRC7 and a closing 1. The CRC7 uses polynomial x^7+x^3+1, starts from zero and covers the first 40 bits.
- R2: A write (`wr_en` high at a clock edge) is accepted only while `cmd_ready` is 1, apart from the case in R8. `cmd_ready` is 0 from the cycle after an accepted write. A write made while busy changes neither the frame in progress nor what follows it.
- R3: `wr_rsp` codes the reply: 0 none, 1 48 bits, 2 136 bits, 3 48 bits followed by a busy wait. After the frame the line is released (`cmd_oe` 0). The first 0 sampled on `cmd_in` is the start bit. From the start bit onward, 48 or 136 bits are shifted into `resp_data`, right-aligned, with the last bit received in bit 0 and the unused upper bits 0.
- R4: If no start bit arrives within 64 clocks after the frame, the command completes with `resp_timeout` set. A start bit sampled in the 64th clock is still taken as a reply. `resp_timeout` clears on the next accepted write.
- R5: For reply code 3, `cmd_ready` stays 0 after the reply until `dat0_in` is sampled high, and completion follows at that edge.
- R6: Special code 1 drives the line high with `cmd_oe` set for exactly 74 clocks, and then sends the frame.
- R7: Special code 2 keeps the line released and the command pending until `blk_end` is sampled high. The frame starts in the cycle after that.
- R8: Special code 4 waits for its reply with no timeout. During that wait a write with special code 5 is accepted and its frame is sent. Any other write is dropped. The lock ends when a command completes.
- R9: `cmd_done` is a one-cycle pulse that comes in the same cycle in which `cmd_ready` returns to 1, and only then.
- R10: Special codes 0, 3, 6 and 7, and code 5 when no interrupt wait is in progress, run as plain commands.
- R11: After reset, `cmd_ready` is 1, `cmd_oe` 0, `cmd_out` 1, `cmd_done` 0 and `resp_timeout` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_index | input | 6 | Command index |
| wr_arg | input | 32 | Command argument |
| wr_rsp | input | 2 | Reply kind code |
| wr_spcmd | input | 3 | Special-command code |
| blk_end | input | 1 | End of the current data block, from the data engine |
| dat0_in | input | 1 | Data line 0 level, used for the busy wait |
| cmd_in | input | 1 | Sampled command line level |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_ready | output | 1 | Sequencer free to take a descriptor |
| cmd_done | output | 1 | One-cycle completion pulse |
| resp_timeout | output | 1 | Last command saw no reply in time |
| resp_data | output | 136 | Captured reply, right-aligned |

## Verification
The assertions assume that the card's reply on `cmd_in` arrives only after the frame has left and that `cmd_in` idles high. They also assume that `dat0_in` matters only in the busy wait and that the descriptor fields are valid whenever `wr_en` is high. The bench acts as a card that keeps `cmd_in` high except while replying, starts a reply only at or after the first released cycle, and holds `dat0_in` low only during R1b busy phases. Writes made while the block is busy go in through the normal strobe at chosen frame positions, so that the lock is exercised without breaking these assumptions.

// File: rtl/sdcmd_pkg.sv
// Shared encodings for the SD/MMC command sequencer.
// Assumes: the reply and special-command codes match the descriptor fields.
package sdcmd_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_BUSY  = 2'd3
    } rsp_kind_e;

    typedef enum logic [2:0] {
        SPC_STD     = 3'd0,
        SPC_INIT    = 3'd1,
        SPC_SYNC    = 3'd2,
        SPC_CEATA   = 3'd3,
        SPC_ITCMD   = 3'd4,
        SPC_ITRESP  = 3'd5,
        SPC_BOOTREQ = 3'd6,
        SPC_BOOTEND = 3'd7
    } spc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_WAIT_BLK,
        ST_SEND,
        ST_WAIT_RSP,
        ST_RECV,
        ST_BUSY
    } seq_state_e;

endpackage

// File: rtl/sdcmd_crc7.sv
// Parallel CRC over a fixed-width message, MSB first, zero initial value.
// Assumes: the message is stable in the cycle it is used; pure combinational.
module sdcmd_crc7 #(
    parameter int                 DATA_W = 40,
    parameter int                 CRC_W  = 7,
    parameter logic [CRC_W-1:0]   POLY   = CRC_W'(9)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    // Unrolled shift-register division over every message bit.
    always_comb begin
        logic fb;
        crc = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = data[i] ^ crc[CRC_W-1];
            crc = {crc[CRC_W-2:0], 1'b0};
            if (fb) begin
                crc = crc ^ POLY;
            end
        end
    end

endmodule

// File: rtl/sdcmd_wrgate.sv
// Write gate for the descriptor: decides whether a strobe is taken and
// tracks the interrupt-mode lock.
// Assumes: cmd_done pulses only when the sequencer returns to idle, and
// reply_wait is high only while the sequencer listens for a reply.
module sdcmd_wrgate
    import sdcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_spcmd,
    input  logic       cmd_ready,
    input  logic       reply_wait,
    input  logic       cmd_done,
    output logic       accept,
    output logic       it_lock
);

    logic is_itresp;
    logic is_itcmd;

    assign is_itresp = (spc_kind_e'(wr_spcmd) == SPC_ITRESP);
    assign is_itcmd  = (spc_kind_e'(wr_spcmd) == SPC_ITCMD);

    // Free sequencer takes anything; a locked wait takes only the reply code.
    assign accept = wr_en && (cmd_ready || (it_lock && reply_wait && is_itresp));

    // Lock follows the code of the last accepted write and drops on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            it_lock <= 1'b0;
        end else if (accept) begin
            it_lock <= is_itcmd;
        end else if (cmd_done) begin
            it_lock <= 1'b0;
        end
    end

    // R8: while locked, the only write let through carries the reply code.
    a_r8_locked_accepts_itresp: assert property (@(posedge clk) disable iff (!rst_n)
        (it_lock && accept) |-> is_itresp);

    // R8: completion without a new write releases the lock.
    a_r8_lock_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !accept) |=> !it_lock);

endmodule

// File: rtl/sdcmd_seq.sv
// SD/MMC command line sequencer. Latches a descriptor, sends a CRC-protected
// 48-bit frame on the command line, optionally collects a 48- or 136-bit
// reply and a busy release, and reports completion.
// Assumes: one clk period is one command-clock period; cmd_in idles high and
// a card replies only after the frame; blk_end comes from the data engine.
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int ARG_W     = 32,
    parameter int CRC_W     = 7,
    parameter int SHORT_W   = 48,
    parameter int LONG_W    = 136,
    parameter int INIT_CLKS = 74,
    parameter int RSP_TMO   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [ARG_W-1:0]  wr_arg,
    input  logic [1:0]        wr_rsp,
    input  logic [2:0]        wr_spcmd,
    input  logic              blk_end,
    input  logic              dat0_in,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              cmd_ready,
    output logic              cmd_done,
    output logic              resp_timeout,
    output logic [LONG_W-1:0] resp_data
);

    localparam int FRAME_W = 3 + IDX_W + ARG_W + CRC_W;
    localparam int BODY_W  = FRAME_W - CRC_W - 1;
    localparam int M_A     = (FRAME_W > LONG_W) ? FRAME_W : LONG_W;
    localparam int M_B     = (INIT_CLKS > RSP_TMO) ? INIT_CLKS : RSP_TMO;
    localparam int MAXC    = (M_A > M_B) ? M_A : M_B;
    localparam int CNT_W   = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_INIT  = CNT_W'(INIT_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST_WAIT  = CNT_W'(RSP_TMO - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    seq_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [FRAME_W-1:0]  frame_q;
    logic [LONG_W-1:0]   resp_q;
    rsp_kind_e           rsp_q;
    logic                ready_q;
    logic                done_q;
    logic                tmo_q;

    logic                accept;
    logic                it_lock;
    logic                reply_wait;
    logic [BODY_W-1:0]   body;
    logic [CRC_W-1:0]    crc_w;
    logic [CNT_W-1:0]    last_rsp;
    logic                tmo_hit;
    logic                finish;
    logic                capture;

    assign reply_wait = (state_q == ST_WAIT_RSP);

    sdcmd_wrgate i_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_spcmd   (wr_spcmd),
        .cmd_ready  (ready_q),
        .reply_wait (reply_wait),
        .cmd_done   (done_q),
        .accept     (accept),
        .it_lock    (it_lock)
    );

    assign body = {2'b01, wr_index, wr_arg};

    sdcmd_crc7 #(
        .DATA_W (BODY_W),
        .CRC_W  (CRC_W)
    ) i_crc (
        .data (body),
        .crc  (crc_w)
    );

    // Reply length selection and the completion conditions of each phase.
    always_comb begin
        last_rsp = (rsp_q == RSP_LONG) ? LAST_LONG : LAST_SHORT;
        tmo_hit  = (state_q == ST_WAIT_RSP) && cmd_in && !it_lock && (cnt_q == LAST_WAIT);
        finish   = ((state_q == ST_SEND) && (cnt_q == LAST_BIT) && (rsp_q == RSP_NONE))
                || tmo_hit
                || ((state_q == ST_RECV) && (cnt_q == last_rsp) && (rsp_q != RSP_BUSY))
                || ((state_q == ST_BUSY) && dat0_in);
        capture  = ((state_q == ST_WAIT_RSP) && !cmd_in) || (state_q == ST_RECV);
    end

    // Phase sequencing, counters and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rsp_q   <= RSP_NONE;
            ready_q <= 1'b1;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            done_q <= finish && !accept;
            if (accept) begin
                ready_q <= 1'b0;
                tmo_q   <= 1'b0;
                rsp_q   <= rsp_kind_e'(wr_rsp);
                cnt_q   <= '0;
                case (spc_kind_e'(wr_spcmd))
                    SPC_INIT: state_q <= ST_INIT;
                    SPC_SYNC: state_q <= ST_WAIT_BLK;
                    default:  state_q <= ST_SEND;
                endcase
            end else if (finish) begin
                state_q <= ST_IDLE;
                ready_q <= 1'b1;
                tmo_q   <= tmo_hit;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    ST_INIT: begin
                        if (cnt_q == LAST_INIT) begin
                            state_q <= ST_SEND;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    ST_WAIT_BLK: begin
                        if (blk_end) begin
                            state_q <= ST_SEND;
                        end
                    end
                    ST_SEND: begin
                        if (cnt_q == LAST_BIT) begin
                            state_q <= ST_WAIT_RSP;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    ST_WAIT_RSP: begin
                        if (!cmd_in) begin
                            state_q <= ST_RECV;
                            cnt_q   <= ONE;
                        end else if (!it_lock) begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    ST_RECV: begin
                        if (cnt_q == last_rsp) begin
                            state_q <= ST_BUSY;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    ST_BUSY: ;
                    ST_IDLE: ;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Outgoing frame: loaded on accept, shifted left while sending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
        end else if (accept) begin
            frame_q <= {body, crc_w, 1'b1};
        end else if (state_q == ST_SEND) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
        end
    end

    // Reply register: cleared on accept, shifts in from the start bit on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (accept) begin
            resp_q <= '0;
        end else if (capture) begin
            resp_q <= {resp_q[LONG_W-2:0], cmd_in};
        end
    end

    assign cmd_out      = (state_q == ST_SEND) ? frame_q[FRAME_W-1] : 1'b1;
    assign cmd_oe       = (state_q == ST_SEND) || (state_q == ST_INIT);
    assign cmd_ready    = ready_q;
    assign cmd_done     = done_q;
    assign resp_timeout = tmo_q;
    assign resp_data    = resp_q;

    // R9: the completion pulse marks the return of ready.
    a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cmd_ready && !$past(cmd_ready)));

    // R9: ready never comes back without a completion pulse.
    a_r9_ready_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> cmd_done);

    // R9: the pulse lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R2: a taken write makes the sequencer busy.
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !cmd_ready);

    // R2: outside the reply wait a busy sequencer takes no write.
    a_r2_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cmd_ready && (state_q != ST_WAIT_RSP)) |-> !accept);

    // R11: an idle sequencer leaves the line released.
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!cmd_oe && cmd_out));

    // R1: a frame opens with a 0 right after the accepting edge.
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(accept) && (state_q == ST_SEND)) |-> !cmd_out);

    // R4: the timeout flag appears only together with completion.
    a_r4_timeout_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_timeout) |-> cmd_done);

    // R5: a low data line holds the busy wait.
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BUSY) && !dat0_in) |=> !cmd_ready);

    // R7: the deferred command stays pending until the block ends.
    a_r7_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_BLK) && !blk_end) |=> (state_q == ST_WAIT_BLK));

    // R8: an interrupt-mode wait never times out.
    a_r8_no_timeout_locked: assert property (@(posedge clk) disable iff (!rst_n)
        it_lock |-> !resp_timeout);

endmodule

// File: tb/test_sdcmd_seq.sv
`timescale 1ns/1ps
// Self-checking bench for the command sequencer, acting as host and card.
module test_sdcmd_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_index = '0;
    logic [31:0]  wr_arg = '0;
    logic [1:0]   wr_rsp = '0;
    logic [2:0]   wr_spcmd = '0;
    logic         blk_end = 1'b0;
    logic         dat0_in = 1'b1;
    logic         cmd_in = 1'b1;
    logic         cmd_out;
    logic         cmd_oe;
    logic         cmd_ready;
    logic         cmd_done;
    logic         resp_timeout;
    logic [135:0] resp_data;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  inj_at = -1;
    logic [5:0] inj_idx = '0;
    logic [2:0] inj_sp = '0;

    always #2 clk = ~clk;

    sdcmd_seq i_sdcmd_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_index     (wr_index),
        .wr_arg       (wr_arg),
        .wr_rsp       (wr_rsp),
        .wr_spcmd     (wr_spcmd),
        .blk_end      (blk_end),
        .dat0_in      (dat0_in),
        .cmd_in       (cmd_in),
        .cmd_out      (cmd_out),
        .cmd_oe       (cmd_oe),
        .cmd_ready    (cmd_ready),
        .cmd_done     (cmd_done),
        .resp_timeout (resp_timeout),
        .resp_data    (resp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // CRC7 by long division of the message times x^7 by x^7+x^3+1.
    function automatic logic [6:0] ref_crc(input logic [39:0] m);
        logic [46:0] r;
        r = {m, 7'b0};
        for (int i = 46; i >= 7; i--) begin
            if (r[i]) r = r ^ (47'h89 << (i - 7));
        end
        return r[6:0];
    endfunction

    function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    endfunction

    // One-cycle write strobe; returns at the negedge after the sampling edge.
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [1:0] rsp, input logic [2:0] sp);
        wr_index = idx; wr_arg = arg; wr_rsp = rsp; wr_spcmd = sp; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Collect 48 line bits; optionally strobe a write at bit position inj_at.
    task automatic grab(output logic [47:0] got, output bit oe_ok);
        got = '0; oe_ok = 1'b1;
        for (int i = 0; i < 48; i++) begin
            if (!cmd_oe) oe_ok = 1'b0;
            got = {got[46:0], cmd_out};
            if (i == inj_at) begin
                wr_index = inj_idx; wr_arg = 32'hFFFF_0000; wr_rsp = 2'd0;
                wr_spcmd = inj_sp; wr_en = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    // Card reply: dly idle cycles, then len bits MSB first.
    task automatic reply(input int dly, input int len, input logic [135:0] bits);
        cmd_in = 1'b1;
        repeat (dly) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = bits[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic frame_chk(input string req, input logic [5:0] idx, input logic [31:0] arg);
        logic [47:0] got;
        bit oe_ok;
        grab(got, oe_ok);
        chk(got == ref_frame(idx, arg), req, "frame bits", got, ref_frame(idx, arg));
        chk(oe_ok, req, "drive enable during frame", 0, 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [47:0]  got;
        bit           oe_ok;
        bit           bad;
        logic [47:0]  pat48;
        logic [135:0] pat136;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk(cmd_ready && !cmd_oe && cmd_out && !cmd_done && !resp_timeout, "R11",
            "reset outputs", {cmd_ready, cmd_oe, cmd_out, cmd_done, resp_timeout}, 5'b10100);

        // R1 known frames
        issue(6'd0, 32'h0, 2'd0, 3'd0);
        grab(got, oe_ok);
        chk(got == 48'h4000_0000_0095, "R1", "CMD0 frame", got, 48'h4000_0000_0095);
        chk(cmd_done && cmd_ready, "R9", "done with ready", {cmd_done, cmd_ready}, 2'b11);
        @(negedge clk);
        chk(!cmd_done && cmd_ready, "R9", "done lasts one cycle", cmd_done, 0);
        issue(6'd17, 32'h0, 2'd0, 3'd0);
        grab(got, oe_ok);
        chk(got == 48'h5100_0000_0055, "R1", "CMD17 frame", got, 48'h5100_0000_0055);
        @(negedge clk);
        issue(6'd8, 32'h0000_01AA, 2'd0, 3'd0);
        grab(got, oe_ok);
        chk(got == 48'h4800_0001_AA87, "R1", "CMD8 frame", got, 48'h4800_0001_AA87);
        @(negedge clk);

        // R1 and R10: sweep every index across the plain special codes
        for (int k = 0; k < 64; k++) begin
            logic [2:0]  sp;
            logic [31:0] arg;
            case (k % 5)
                0: sp = 3'd0;
                1: sp = 3'd3;
                2: sp = 3'd6;
                3: sp = 3'd7;
                default: sp = 3'd5;
            endcase
            arg = (32'(k) * 32'h0102_0408) ^ 32'h5A00_00C3;
            issue(6'(k), arg, 2'd0, sp);
            frame_chk("R1/R10", 6'(k), arg);
            chk(cmd_done && cmd_ready, "R10", "plain code completes", {cmd_done, cmd_ready}, 2'b11);
            @(negedge clk);
        end

        // R3 short reply
        issue(6'd17, 32'h0000_0200, 2'd1, 3'd0);
        frame_chk("R3", 6'd17, 32'h0000_0200);
        chk(!cmd_oe && !cmd_ready, "R3", "line released after frame", cmd_oe, 0);
        pat48 = 48'h11DE_ADBE_EF79;
        reply(5, 48, {88'b0, pat48});
        chk(cmd_done && cmd_ready && !resp_timeout, "R3", "short reply completes",
            {cmd_done, cmd_ready, resp_timeout}, 3'b110);
        chk(resp_data == {88'b0, pat48}, "R3", "short reply data", resp_data, {88'b0, pat48});
        @(negedge clk);

        // R3 long reply
        issue(6'd2, 32'h0, 2'd2, 3'd0);
        frame_chk("R3", 6'd2, 32'h0);
        pat136 = 136'h3F_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        reply(0, 136, pat136);
        chk(cmd_done && cmd_ready, "R3", "long reply completes", {cmd_done, cmd_ready}, 2'b11);
        chk(resp_data == pat136, "R3", "long reply data", resp_data, pat136);
        @(negedge clk);

        // R4 timeout after 64 silent cycles
        issue(6'd5, 32'h0, 2'd1, 3'd0);
        frame_chk("R4", 6'd5, 32'h0);
        bad = 1'b0;
        repeat (63) begin
            @(negedge clk);
            if (cmd_done || cmd_ready) bad = 1'b1;
        end
        chk(!bad, "R4", "no completion before 64 cycles", bad, 0);
        @(negedge clk);
        chk(cmd_done && cmd_ready && resp_timeout, "R4", "timeout at 64th cycle",
            {cmd_done, cmd_ready, resp_timeout}, 3'b111);
        @(negedge clk);
        issue(6'd0, 32'h0, 2'd0, 3'd0);
        chk(!resp_timeout, "R4", "timeout cleared by new write", resp_timeout, 0);
        grab(got, oe_ok);
        @(negedge clk);

        // R4 boundary: start bit in the 64th cycle is still a reply
        issue(6'd6, 32'h0000_0001, 2'd1, 3'd0);
        frame_chk("R4", 6'd6, 32'h0000_0001);
        pat48 = 48'h06C0_FFEE_0011;
        reply(63, 48, {88'b0, pat48});
        chk(cmd_done && !resp_timeout, "R4", "late start bit accepted",
            {cmd_done, resp_timeout}, 2'b10);
        chk(resp_data == {88'b0, pat48}, "R4", "late reply data", resp_data, {88'b0, pat48});
        @(negedge clk);

        // R5 busy wait on data line 0
        issue(6'd7, 32'h0000_1234, 2'd3, 3'd0);
        frame_chk("R5", 6'd7, 32'h0000_1234);
        dat0_in = 1'b0;
        pat48 = 48'h0700_0000_0901;
        reply(2, 48, {88'b0, pat48});
        chk(!cmd_ready && !cmd_done, "R5", "busy after reply", cmd_ready, 0);
        repeat (10) @(negedge clk);
        chk(!cmd_ready, "R5", "busy while data line low", cmd_ready, 0);
        dat0_in = 1'b1;
        @(negedge clk);
        chk(cmd_done && cmd_ready, "R5", "release ends busy", {cmd_done, cmd_ready}, 2'b11);
        chk(resp_data == {88'b0, pat48}, "R5", "reply data kept", resp_data, {88'b0, pat48});
        @(negedge clk);
        issue(6'd8, 32'h0, 2'd3, 3'd0);
        grab(got, oe_ok);
        reply(0, 48, {88'b0, pat48});
        chk(!cmd_ready, "R5", "one busy cycle with line already high", cmd_ready, 0);
        @(negedge clk);
        chk(cmd_done && cmd_ready, "R5", "immediate release", {cmd_done, cmd_ready}, 2'b11);
        @(negedge clk);

        // R6 initialisation burst
        issue(6'd0, 32'h0, 2'd0, 3'd1);
        bad = 1'b0;
        for (int i = 0; i < 74; i++) begin
            if (!(cmd_oe && cmd_out)) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R6", "74 driven ones", bad, 0);
        frame_chk("R6", 6'd0, 32'h0);
        chk(cmd_done, "R6", "init command completes", cmd_done, 1);
        @(negedge clk);

        // R7 deferred until block end
        issue(6'd12, 32'hCAFE_0001, 2'd0, 3'd2);
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (cmd_oe || cmd_ready) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R7", "held with line released", bad, 0);
        blk_end = 1'b1;
        @(negedge clk);
        blk_end = 1'b0;
        frame_chk("R7", 6'd12, 32'hCAFE_0001);
        chk(cmd_done, "R7", "deferred command completes", cmd_done, 1);
        @(negedge clk);

        // R2 writes while busy are dropped
        for (int v = 0; v < 2; v++) begin
            inj_at = 10 + 20 * v; inj_idx = 6'd9; inj_sp = (v == 0) ? 3'd0 : 3'd5;
            issue(6'd3, 32'h0BAD_F00D, 2'd0, 3'd0);
            frame_chk("R2", 6'd3, 32'h0BAD_F00D);
            inj_at = -1;
            chk(cmd_done, "R2", "original command completes", cmd_done, 1);
            bad = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (cmd_oe || !cmd_ready) bad = 1'b1;
            end
            chk(!bad, "R2", "dropped write leaves no command", bad, 0);
        end

        // R8 interrupt-mode wait and reply
        issue(6'd40, 32'h0000_1111, 2'd1, 3'd4);
        frame_chk("R8", 6'd40, 32'h0000_1111);
        bad = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (cmd_ready || cmd_done || resp_timeout || cmd_oe) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R8", "waits beyond timeout", bad, 0);
        issue(6'd1, 32'h0000_5555, 2'd0, 3'd0);
        chk(!cmd_oe && !cmd_ready, "R8", "other write dropped", cmd_oe, 0);
        @(negedge clk);
        chk(!cmd_oe && !cmd_ready, "R8", "still waiting", cmd_oe, 0);
        issue(6'd40, 32'h0, 2'd0, 3'd5);
        frame_chk("R8", 6'd40, 32'h0);
        chk(cmd_done && cmd_ready && !resp_timeout, "R8", "reply command completes",
            {cmd_done, cmd_ready, resp_timeout}, 3'b110);
        @(negedge clk);
        issue(6'd0, 32'h0, 2'd0, 3'd0);
        frame_chk("R8", 6'd0, 32'h0);
        chk(cmd_done, "R8", "lock released", cmd_done, 1);
        @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule